// File: doc/BRIEF.md
# Mailbox Command Dispatcher and Validator

This block sits between a mailbox request port and a set of command handlers. A request is made of an 8-bit command-set code, an 8-bit command code and an input payload length. The block joins the two codes into one 16-bit opcode and looks that opcode up in a fixed table of supported commands. It checks the payload length against the size that the command expects, then either rejects the request with a completion code or selects exactly one handler. When that handler signals done, the block returns its result.

The same table feeds a command effects log. After reset the block walks the table in ascending opcode order, one entry per cycle. Each supported opcode is appended to a small RAM together with its effect flags. Requests that arrive during this walk are refused as busy. Once the walk is finished, software-facing logic can read the log by index and can read the entry count and the log size in bytes.

Top module: `mbx_dispatcher`

## Requirements
- R1: The opcode is `{req_set, req_cmd}`. Bit i of `handler_sel` belongs to table entry i. The entries are held in ascending opcode order: 0=0x0100, 1=0x0101, 2=0x0102, 3=0x0103, 4=0x0200, 5=0x0300, 6=0x0301, 7=0x0400, 8=0x0401, 9=0x4000, 10=0x4100, 11=0x4102, 12=0x4103, 13=0x4300, 14=0x4301, 15=0x4302.
- R2: A start with an opcode not in the table completes one cycle later with `cpl_code` = 1 (unsupported), and no handler is selected.
- R3: Expected lengths are as follows. 0x0100 needs 1. 0x0301 needs 8. 0x0401 needs 0x18. 0x4102 needs 8. 0x4300 needs 16. 0x4301 needs 8. 0x4302 needs 72. Entries 0x0101, 0x0103 and 0x4103 hold 0xFFFF and accept any length. All other entries need 0. A length that does not match completes one cycle after start with `cpl_code` = 2.
- R4: An accepted start raises the one-hot `handler_sel` one cycle later and holds it until `handler_done`. The cycle after done, `cpl_valid` pulses with `cpl_code` = 0 and `cpl_len` = `handler_len`, and `handler_sel` returns to zero.
- R5: Every rejected completion reports `cpl_len` = 0. The output length is cleared at acceptance, before any handler runs.
- R6: After reset, `req_busy` stays high for 16 cycles while the log is built, and it never rises again. A start while busy completes one cycle later with `cpl_code` = 3 and no handler selected.
- R7: Reading log index k gives `{opcode[15:0], effect[7:0]}` for the k-th table entry, one cycle after the index is applied. The effect bits are: bit1 config change, bit2 data change, bit3 policy change, bit4 log change. The nonzero values are 0x0101→0x10, 0x0103→0x02, 0x0301→0x08 and 0x4103→0x06. All others are 0.
- R8: Once built, `log_count` = 16 and `log_bytes` = 64 (four times the count), and both stay constant.
- R9: A start that arrives while a handler is selected is ignored. The select does not change and no completion is produced.
- R10: While reset is held, `req_busy` = 1, `handler_sel` = 0, `cpl_valid` = 0 and `log_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe |
| req_set | input | 8 | Command-set code |
| req_cmd | input | 8 | Command code within the set |
| req_len | input | LEN_W | Input payload length in bytes |
| req_busy | output | 1 | Effects log still being built |
| handler_sel | output | N | One-hot handler select |
| handler_done | input | 1 | Selected handler has finished |
| handler_len | input | LEN_W | Output length produced by the handler |
| cpl_valid | output | 1 | Completion strobe |
| cpl_code | output | 4 | 0 ok, 1 unsupported, 2 bad length, 3 busy |
| cpl_len | output | LEN_W | Output payload length |
| log_rd_idx | input | IW | Effects log read index |
| log_rd_data | output | 24 | Opcode and effect flags at the read index |
| log_count | output | IW+1 | Number of log entries |
| log_bytes | output | IW+3 | Log size in bytes |

## Verification
The checks assume that `handler_done` is raised only while a handler is selected. They also assume that `handler_len` is valid in that same cycle and that request fields are stable while `req_start` is high. The bench drives every input at the falling edge. It raises done only after it has seen the select at the outputs, and it holds done for a single cycle. This keeps the handler side within those assumptions, including the run where a second start is sent during an open handler.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [3:0] {
    CPL_OK     = 4'd0,
    CPL_UNSUP  = 4'd1,
    CPL_BADLEN = 4'd2,
    CPL_BUSY   = 4'd3
  } cpl_e;

  typedef struct packed {
    logic        valid;
    logic [15:0] opcode;
    logic [15:0] exp_len;
    logic [7:0]  effect;
  } cmd_ent_t;

  localparam logic [7:0]  EFF_CFG  = 8'h02;
  localparam logic [7:0]  EFF_DATA = 8'h04;
  localparam logic [7:0]  EFF_POL  = 8'h08;
  localparam logic [7:0]  EFF_LOG  = 8'h10;
  localparam logic [15:0] LEN_ANY  = 16'hFFFF;

  // Table entries in ascending opcode order; index beyond the list is empty.
  function automatic cmd_ent_t cmd_rom(input int unsigned idx);
    case (idx)
      0:  return '{1'b1, 16'h0100, 16'd1,   8'h00};
      1:  return '{1'b1, 16'h0101, LEN_ANY, EFF_LOG};
      2:  return '{1'b1, 16'h0102, 16'd0,   8'h00};
      3:  return '{1'b1, 16'h0103, LEN_ANY, EFF_CFG};
      4:  return '{1'b1, 16'h0200, 16'd0,   8'h00};
      5:  return '{1'b1, 16'h0300, 16'd0,   8'h00};
      6:  return '{1'b1, 16'h0301, 16'd8,   EFF_POL};
      7:  return '{1'b1, 16'h0400, 16'd0,   8'h00};
      8:  return '{1'b1, 16'h0401, 16'h18,  8'h00};
      9:  return '{1'b1, 16'h4000, 16'd0,   8'h00};
      10: return '{1'b1, 16'h4100, 16'd0,   8'h00};
      11: return '{1'b1, 16'h4102, 16'd8,   8'h00};
      12: return '{1'b1, 16'h4103, LEN_ANY, EFF_CFG | EFF_DATA};
      13: return '{1'b1, 16'h4300, 16'd16,  8'h00};
      14: return '{1'b1, 16'h4301, 16'd8,   8'h00};
      15: return '{1'b1, 16'h4302, 16'd72,  8'h00};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mbx_cmd_table.sv
module mbx_cmd_table
  import mbx_pkg::*;
#(
  parameter int N     = 16,
  parameter int LEN_W = 16,
  localparam int IW   = $clog2(N)
) (
  input  logic [15:0]      req_opcode,
  input  logic [LEN_W-1:0] req_len,
  output logic [N-1:0]     hit_vec,
  output logic             hit,
  output logic             len_ok,
  input  logic [IW-1:0]    scan_idx,
  output logic             scan_valid,
  output logic [23:0]      scan_word
);
  cmd_ent_t    rom [N];
  logic [15:0] sel_len;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign rom[i]     = cmd_rom(i);
    assign hit_vec[i] = rom[i].valid && (rom[i].opcode == req_opcode);
  end

  always_comb begin
    sel_len = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) sel_len = sel_len | rom[i].exp_len;
    end
  end

  assign hit        = |hit_vec;
  assign len_ok     = (sel_len == LEN_ANY) || (LEN_W'(sel_len) == req_len);
  assign scan_valid = rom[scan_idx].valid;
  assign scan_word  = {rom[scan_idx].opcode, rom[scan_idx].effect};
endmodule

// File: rtl/mbx_cel_log.sv
module mbx_cel_log #(
  parameter int N   = 16,
  localparam int IW = $clog2(N),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] scan_idx,
  input  logic          scan_valid,
  input  logic [23:0]   scan_word,
  output logic          busy,
  output logic [CW-1:0] count,
  input  logic [IW-1:0] rd_idx,
  output logic [23:0]   rd_data
);
  logic [23:0] ram [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_idx <= '0;
      busy     <= 1'b1;
      count    <= '0;
    end else if (busy) begin
      if (scan_valid) count <= count + 1'b1;
      if (scan_idx == IW'(N - 1)) busy <= 1'b0;
      else                        scan_idx <= scan_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (busy && scan_valid && !rst) ram[count[IW-1:0]] <= scan_word;
    rd_data <= ram[rd_idx];
  end
endmodule

// File: rtl/mbx_req_fsm.sv
module mbx_req_fsm
  import mbx_pkg::*;
#(
  parameter int N     = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic             busy,
  input  logic             hit,
  input  logic             len_ok,
  input  logic [N-1:0]     hit_vec,
  input  logic             hdl_done,
  input  logic [LEN_W-1:0] hdl_len,
  output logic [N-1:0]     handler_sel,
  output logic             cpl_valid,
  output logic [3:0]       cpl_code,
  output logic [LEN_W-1:0] cpl_len
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      handler_sel <= '0;
      cpl_valid   <= 1'b0;
      cpl_code    <= CPL_OK;
      cpl_len     <= '0;
    end else begin
      cpl_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_start) begin
          cpl_len <= '0;
          if (busy) begin
            cpl_valid <= 1'b1;
            cpl_code  <= CPL_BUSY;
          end else if (!hit) begin
            cpl_valid <= 1'b1;
            cpl_code  <= CPL_UNSUP;
          end else if (!len_ok) begin
            cpl_valid <= 1'b1;
            cpl_code  <= CPL_BADLEN;
          end else begin
            handler_sel <= hit_vec;
            st          <= ST_WAIT;
          end
        end
        ST_WAIT: if (hdl_done) begin
          handler_sel <= '0;
          cpl_valid   <= 1'b1;
          cpl_code    <= CPL_OK;
          cpl_len     <= hdl_len;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_dispatcher.sv
module mbx_dispatcher #(
  parameter int N     = 16,
  parameter int LEN_W = 16,
  localparam int IW   = $clog2(N),
  localparam int CW   = IW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [7:0]       req_set,
  input  logic [7:0]       req_cmd,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_busy,
  output logic [N-1:0]     handler_sel,
  input  logic             handler_done,
  input  logic [LEN_W-1:0] handler_len,
  output logic             cpl_valid,
  output logic [3:0]       cpl_code,
  output logic [LEN_W-1:0] cpl_len,
  input  logic [IW-1:0]    log_rd_idx,
  output logic [23:0]      log_rd_data,
  output logic [CW-1:0]    log_count,
  output logic [CW+1:0]    log_bytes
);
  logic [N-1:0]  hit_vec;
  logic          hit, len_ok, scan_valid;
  logic [IW-1:0] scan_idx;
  logic [23:0]   scan_word;

  mbx_cmd_table #(.N(N), .LEN_W(LEN_W)) u_table (
    .req_opcode ({req_set, req_cmd}),
    .req_len    (req_len),
    .hit_vec    (hit_vec),
    .hit        (hit),
    .len_ok     (len_ok),
    .scan_idx   (scan_idx),
    .scan_valid (scan_valid),
    .scan_word  (scan_word)
  );

  mbx_cel_log #(.N(N)) u_log (
    .clk        (clk),
    .rst        (rst),
    .scan_idx   (scan_idx),
    .scan_valid (scan_valid),
    .scan_word  (scan_word),
    .busy       (req_busy),
    .count      (log_count),
    .rd_idx     (log_rd_idx),
    .rd_data    (log_rd_data)
  );

  mbx_req_fsm #(.N(N), .LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_start   (req_start),
    .busy        (req_busy),
    .hit         (hit),
    .len_ok      (len_ok),
    .hit_vec     (hit_vec),
    .hdl_done    (handler_done),
    .hdl_len     (handler_len),
    .handler_sel (handler_sel),
    .cpl_valid   (cpl_valid),
    .cpl_code    (cpl_code),
    .cpl_len     (cpl_len)
  );

  assign log_bytes = {log_count, 2'b00};
endmodule

// File: rtl/mbx_dispatcher_chk.sv
module mbx_dispatcher_chk #(
  parameter int N     = 16,
  parameter int LEN_W = 16,
  localparam int IW   = $clog2(N),
  localparam int CW   = IW + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_start,
  input logic             req_busy,
  input logic [N-1:0]     handler_sel,
  input logic             handler_done,
  input logic [LEN_W-1:0] handler_len,
  input logic             cpl_valid,
  input logic [3:0]       cpl_code,
  input logic [LEN_W-1:0] cpl_len,
  input logic [CW-1:0]    log_count
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(handler_sel)); // R4
  AST_SEL_NO_CPL: assert property (@(posedge clk) disable iff (rst)
    (handler_sel != '0) |-> !cpl_valid); // R4
  AST_DONE_CPL: assert property (@(posedge clk) disable iff (rst)
    (handler_sel != '0 && handler_done) |=>
      (cpl_valid && cpl_code == 4'd0 && handler_sel == '0 && cpl_len == $past(handler_len))); // R4
  AST_REJECT_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && cpl_code != 4'd0) |-> (cpl_len == '0)); // R5
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (req_start && req_busy && handler_sel == '0) |=>
      (cpl_valid && cpl_code == 4'd3 && handler_sel == '0)); // R6
  AST_BUSY_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
    !req_busy |=> !req_busy); // R6
  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !req_busy |=> $stable(log_count)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (handler_sel != '0 && !handler_done) |=> $stable(handler_sel)); // R9
endmodule

bind mbx_dispatcher mbx_dispatcher_chk #(.N(N), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_start    (req_start),
  .req_busy     (req_busy),
  .handler_sel  (handler_sel),
  .handler_done (handler_done),
  .handler_len  (handler_len),
  .cpl_valid    (cpl_valid),
  .cpl_code     (cpl_code),
  .cpl_len      (cpl_len),
  .log_count    (log_count)
);

// File: tb/test_mbx_dispatcher.sv
`timescale 1ns/1ps
module test_mbx_dispatcher;
  localparam int N = 16;
  localparam int LEN_W = 16;
  localparam int IW = $clog2(N);
  localparam int CW = IW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 1'b0;
  logic [7:0] req_set = '0, req_cmd = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_busy;
  logic [N-1:0] handler_sel;
  logic handler_done = 1'b0;
  logic [LEN_W-1:0] handler_len = '0;
  logic cpl_valid;
  logic [3:0] cpl_code;
  logic [LEN_W-1:0] cpl_len;
  logic [IW-1:0] log_rd_idx = '0;
  logic [23:0] log_rd_data;
  logic [CW-1:0] log_count;
  logic [CW+1:0] log_bytes;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mbx_dispatcher #(.N(N), .LEN_W(LEN_W)) i_mbx_dispatcher (.*);

  // {set, cmd, len, expected code, expected select index}
  localparam logic [39:0] VEC [17] = '{
    {8'h01, 8'h00, 16'd1,     4'd0, 4'd0},   // R3 exact length
    {8'h01, 8'h00, 16'd0,     4'd2, 4'd0},   // R3 mismatch
    {8'h01, 8'h01, 16'd0,     4'd0, 4'd1},   // R3 wildcard
    {8'h01, 8'h01, 16'd300,   4'd0, 4'd1},   // R3 wildcard
    {8'h01, 8'h03, 16'd5,     4'd0, 4'd3},   // R1
    {8'h02, 8'h00, 16'd0,     4'd0, 4'd4},   // R1
    {8'h03, 8'h01, 16'd8,     4'd0, 4'd6},   // R3
    {8'h03, 8'h01, 16'd7,     4'd2, 4'd0},   // R3
    {8'h04, 8'h01, 16'h18,    4'd0, 4'd8},   // R3
    {8'h41, 8'h03, 16'd1000,  4'd0, 4'd12},  // R3 wildcard
    {8'h43, 8'h02, 16'd72,    4'd0, 4'd15},  // R3
    {8'h43, 8'h02, 16'd71,    4'd2, 4'd0},   // R3
    {8'h01, 8'h04, 16'd0,     4'd1, 4'd0},   // R2
    {8'h41, 8'h01, 16'd8,     4'd1, 4'd0},   // R2
    {8'hFF, 8'hFF, 16'hFFFF,  4'd1, 4'd0},   // R2
    {8'h43, 8'h00, 16'd16,    4'd0, 4'd13},  // R1
    {8'h40, 8'h00, 16'd0,     4'd0, 4'd9}    // R1
  };

  localparam logic [15:0] EXP_OP [16] = '{
    16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200, 16'h0300, 16'h0301, 16'h0400,
    16'h0401, 16'h4000, 16'h4100, 16'h4102, 16'h4103, 16'h4300, 16'h4301, 16'h4302};
  localparam logic [7:0] EXP_EFF [16] = '{
    8'h00, 8'h10, 8'h00, 8'h02, 8'h00, 8'h00, 8'h08, 8'h00,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h06, 8'h00, 8'h00, 8'h00};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] s, input logic [7:0] c, input logic [LEN_W-1:0] l);
    @(negedge clk);
    req_set = s; req_cmd = c; req_len = l; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", 32'(req_busy), 32'd1);
    chk("R10", "sel in reset", 32'(handler_sel), 32'd0);
    chk("R10", "cpl_valid in reset", 32'(cpl_valid), 32'd0);
    chk("R10", "count in reset", 32'(log_count), 32'd0);
    rst = 1'b0;

    // R6: request during log construction is refused
    pulse_start(8'h01, 8'h00, 16'd1);
    chk("R6", "busy code", 32'(cpl_code), 32'd3);
    chk("R6", "busy cpl_valid", 32'(cpl_valid), 32'd1);
    chk("R6", "busy no sel", 32'(handler_sel), 32'd0);
    chk("R6", "still busy", 32'(req_busy), 32'd1);

    repeat (20) @(negedge clk);
    chk("R6", "busy cleared", 32'(req_busy), 32'd0);
    chk("R8", "log count", 32'(log_count), 32'd16);
    chk("R8", "log bytes", 32'(log_bytes), 32'd64);

    // R7: log contents in opcode order
    for (int k = 0; k < 16; k++) begin
      log_rd_idx = IW'(k);
      @(negedge clk);
      chk("R7", "log entry", 32'(log_rd_data), 32'({EXP_OP[k], EXP_EFF[k]}));
    end

    // Vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < 17; v++) begin
      pulse_start(VEC[v][39:32], VEC[v][31:24], VEC[v][23:8]);
      if (VEC[v][7:4] != 4'd0) begin
        chk("R2/R3", "reject code", 32'(cpl_code), 32'(VEC[v][7:4]));
        chk("R2/R3", "reject valid", 32'(cpl_valid), 32'd1);
        chk("R2", "reject no sel", 32'(handler_sel), 32'd0);
        chk("R5", "reject len", 32'(cpl_len), 32'd0);
      end else begin
        chk("R1", "select", 32'(handler_sel), 32'(1 << VEC[v][3:0]));
        chk("R4", "no early cpl", 32'(cpl_valid), 32'd0);
        chk("R5", "len cleared", 32'(cpl_len), 32'd0);
        handler_len = LEN_W'(16'h00A0 + v);
        handler_done = 1'b1;
        @(negedge clk);
        handler_done = 1'b0;
        chk("R4", "done valid", 32'(cpl_valid), 32'd1);
        chk("R4", "done code", 32'(cpl_code), 32'd0);
        chk("R4", "done len", 32'(cpl_len), 32'(16'h00A0 + v));
        chk("R4", "sel dropped", 32'(handler_sel), 32'd0);
        @(negedge clk);
        chk("R4", "valid one cycle", 32'(cpl_valid), 32'd0);
      end
    end

    // R9: start during an open handler is ignored
    pulse_start(8'h03, 8'h00, 16'd0);
    chk("R9", "first select", 32'(handler_sel), 32'h20);
    pulse_start(8'h04, 8'h01, 16'h18);
    chk("R9", "select unchanged", 32'(handler_sel), 32'h20);
    chk("R9", "no completion", 32'(cpl_valid), 32'd0);
    handler_len = 16'h0055;
    handler_done = 1'b1;
    @(negedge clk);
    handler_done = 1'b0;
    chk("R9", "completion of first", 32'(cpl_len), 32'h55);
    @(negedge clk);
    chk("R9", "no extra completion", 32'(cpl_valid), 32'd0);
    chk("R8", "count stable", 32'(log_count), 32'd16);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule